// File: doc/BRIEF.md
# Single-Vector Interrupt Sequencer

This block sits between a small CPU core and its peripherals. Peripherals report events as one-cycle pulses. Each pulse sets a sticky bit in one of two 8-bit pending banks. Any pending bit raises one shared interrupt request, provided that a global mask bit is clear and that no re-enable hold-off is running. The request is acted on only at an instruction boundary. The core marks each boundary with a strobe.

When a request meets a boundary, the block takes the vector. In that same cycle it reports a fixed vector PC of 0x3FF7. It then sets the mask again and saves the return context. The return context is the 14-bit address of the next instruction plus the carry and zero flags, all packed into a 16-bit return register. Software uses a byte-wide bus port to do four things: poll and acknowledge the pending bits, set or clear the mask, read or rewrite the return register, and read a fixed jump opcode. That opcode sits at the address just below the return register, so a jump there continues through the saved address.

Top module: `svi_sequencer`

## Requirements
- R1: `irq_o` is high in the same cycle whenever at least one pending bit is set, the mask is clear and no hold-off is running.
- R2: While the mask is set, `irq_o` stays low. Pending bits still read back on the bus (bank 0 at address 0 for flags 7:0, bank 1 at address 1 for flags 15:8) so that software can poll them.
- R3: `vec_take_o` is high in exactly the cycles where `irq_o` and `insn_done_i` are both high. In such a cycle, `vec_pc_o` is 0x3FF7.
- R4: After a take, the mask reads 1 from the next cycle on, and `irq_o` is low.
- R5: A take loads the return register from the inputs of that cycle. The high byte (address 5) holds C in bit 7, Z in bit 6 and PC[13:8] in bits 5:0. The low byte (address 6) holds PC[7:0]. `ret_pc_o`, `ret_c_o` and `ret_z_o` show the stored fields.
- R6: Address 4 always reads 0xBC, and writes to it change nothing. Addresses 3 and 7 read 0.
- R7: The mask is bit 0 at address 2, and the other bits of that address read 0. A write that moves the mask from 1 to 0 keeps `irq_o` low for the next three cycles, whatever is pending. `irq_o` may rise in the fourth cycle.
- R8: A pulse on `flag_set_i[i]` sets pending bit i in the next cycle. Writing 1 to a pending bit clears it, and writing 0 has no effect. A set and a clear of the same bit in the same cycle leaves the bit set.
- R9: After reset, both pending banks read 0, the mask reads 1, the return register reads 0 and `irq_o` is low.
- R10: If the mask is cleared while nothing is pending, no request appears. A flag that arrives after the hold-off has run out raises `irq_o` in the first cycle it is pending.
- R11: Bus writes to addresses 5 and 6 load the return register. If a take happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set_i | input | 16 | Peripheral event pulses, one per pending bit |
| insn_done_i | input | 1 | Instruction boundary strobe |
| next_pc_i | input | 14 | Address of the instruction that would run next |
| ccr_c_i | input | 1 | Current carry flag |
| ccr_z_i | input | 1 | Current zero flag |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | Bus write when high, read when low |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Shared interrupt request |
| vec_take_o | output | 1 | Vectoring taken this cycle; the core loads `vec_pc_o` |
| vec_pc_o | output | 14 | Fixed vector address |
| ret_pc_o | output | 14 | Saved return PC |
| ret_c_o | output | 1 | Saved carry flag |
| ret_z_o | output | 1 | Saved zero flag |

## Verification
The bench builds the block with its default parameters: a three-cycle hold-off, vector 0x3FF7 and exit opcode 0xBC. The short hold-off makes it possible to step through the whole re-enable window cycle by cycle and to watch the request rise exactly one cycle after the window ends. Because the vector and opcode are fixed, the packed return bytes and the exit byte can be checked against literal values. The scenarios also reach the mask-clear with nothing pending, the set-versus-clear collision in a pending bank, and a take that collides with a software write to the return register.

// File: rtl/svi_pkg.sv
package svi_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NBANK  = 2;
  localparam int unsigned FLAG_W = DATA_W * NBANK;
  localparam int unsigned PC_W   = 14;
  localparam int unsigned RET_W  = PC_W + 2;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PEND0 = 3'd0,
    A_PEND1 = 3'd1,
    A_CTRL  = 3'd2,
    A_RSV3  = 3'd3,
    A_EXIT  = 3'd4,
    A_RETH  = 3'd5,
    A_RETL  = 3'd6,
    A_RSV7  = 3'd7
  } reg_addr_e;

  // Sticky bank update: acknowledged bits drop, new events win.
  function automatic logic [DATA_W-1:0] pend_update(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] clr,
                                                   input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Return word: carry, zero, then the PC.
  function automatic logic [RET_W-1:0] pack_ret(input logic c, input logic z,
                                                input logic [PC_W-1:0] pc);
    return {c, z, pc};
  endfunction

  function automatic int unsigned hold_dec(input int unsigned cnt);
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction
endpackage

// File: rtl/svi_pending.sv
module svi_pending import svi_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [NBANK-1:0]  clr_we_i,
  input  logic [DATA_W-1:0] clr_data_i,
  output logic [FLAG_W-1:0] pend_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] bank_q;
    logic [DATA_W-1:0] clr;
    assign clr = clr_we_i[b] ? clr_data_i : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= pend_update(bank_q, clr, set_i[b*DATA_W +: DATA_W]);
    end
    assign pend_o[b*DATA_W +: DATA_W] = bank_q;
  end
endmodule

// File: rtl/svi_mask_ctl.sv
module svi_mask_ctl import svi_pkg::*; #(
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic take_i,
  output logic mask_o,
  output logic hold_o
);
  localparam int unsigned HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic          mask_q;
  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_dec;
  logic          reopen;

  assign cnt_dec = HW'(hold_dec(int'(cnt_q)));
  assign reopen  = wr_i && mask_q && !wr_val_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      cnt_q  <= '0;
    end else if (take_i) begin
      mask_q <= 1'b1;
      cnt_q  <= '0;
    end else if (wr_i) begin
      mask_q <= wr_val_i;
      if (reopen)        cnt_q <= HW'(HOLD_CYC);
      else if (wr_val_i) cnt_q <= '0;
      else               cnt_q <= cnt_dec;
    end else begin
      cnt_q <= cnt_dec;
    end
  end

  assign mask_o = mask_q;
  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/svi_ret_reg.sv
module svi_ret_reg import svi_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [RET_W-1:0]  ret_o
);
  logic [RET_W-1:0] ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
    end else if (cap_i) begin
      ret_q <= pack_ret(c_i, z_i, pc_i);
    end else begin
      if (wr_hi_i) ret_q[RET_W-1 -: DATA_W] <= wdata_i;
      if (wr_lo_i) ret_q[DATA_W-1:0]        <= wdata_i;
    end
  end

  assign ret_o = ret_q;
endmodule

// File: rtl/svi_sequencer.sv
module svi_sequencer import svi_pkg::*; #(
  parameter int unsigned          HOLD_CYC = 3,
  parameter logic [PC_W-1:0]      VEC_PC   = 14'h3FF7,
  parameter logic [DATA_W-1:0]    EXIT_OPC = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_set_i,
  input  logic              insn_done_i,
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic              ccr_c_i,
  input  logic              ccr_z_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              vec_take_o,
  output logic [PC_W-1:0]   vec_pc_o,
  output logic [PC_W-1:0]   ret_pc_o,
  output logic              ret_c_o,
  output logic              ret_z_o
);
  // Named internal events, visible to the bound checker.
  logic              bus_wr;
  logic [NBANK-1:0]  pend_clr_we;
  logic              ctrl_wr;
  logic              reth_wr;
  logic              retl_wr;
  logic [FLAG_W-1:0] pend_q;
  logic              pend_any;
  logic              mask_q;
  logic              hold_q;
  logic [RET_W-1:0]  ret_q;

  assign bus_wr         = bus_sel_i && bus_we_i;
  assign pend_clr_we[0] = bus_wr && (bus_addr_i == A_PEND0);
  assign pend_clr_we[1] = bus_wr && (bus_addr_i == A_PEND1);
  assign ctrl_wr        = bus_wr && (bus_addr_i == A_CTRL);
  assign reth_wr        = bus_wr && (bus_addr_i == A_RETH);
  assign retl_wr        = bus_wr && (bus_addr_i == A_RETL);

  svi_pending u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (flag_set_i),
    .clr_we_i   (pend_clr_we),
    .clr_data_i (bus_wdata_i),
    .pend_o     (pend_q)
  );

  svi_mask_ctl #(.HOLD_CYC(HOLD_CYC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ctrl_wr),
    .wr_val_i (bus_wdata_i[0]),
    .take_i   (vec_take_o),
    .mask_o   (mask_q),
    .hold_o   (hold_q)
  );

  svi_ret_reg u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (vec_take_o),
    .c_i     (ccr_c_i),
    .z_i     (ccr_z_i),
    .pc_i    (next_pc_i),
    .wr_hi_i (reth_wr),
    .wr_lo_i (retl_wr),
    .wdata_i (bus_wdata_i),
    .ret_o   (ret_q)
  );

  assign pend_any   = |pend_q;
  assign irq_o      = pend_any && !mask_q && !hold_q;
  assign vec_take_o = irq_o && insn_done_i;
  assign vec_pc_o   = VEC_PC;
  assign ret_pc_o   = ret_q[PC_W-1:0];
  assign ret_c_o    = ret_q[RET_W-1];
  assign ret_z_o    = ret_q[RET_W-2];

  always_comb begin
    unique case (reg_addr_e'(bus_addr_i))
      A_PEND0: bus_rdata_o = pend_q[DATA_W-1:0];
      A_PEND1: bus_rdata_o = pend_q[FLAG_W-1 -: DATA_W];
      A_CTRL:  bus_rdata_o = {{(DATA_W-1){1'b0}}, mask_q};
      A_EXIT:  bus_rdata_o = EXIT_OPC;
      A_RETH:  bus_rdata_o = ret_q[RET_W-1 -: DATA_W];
      A_RETL:  bus_rdata_o = ret_q[DATA_W-1:0];
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/svi_sequencer_chk.sv
module svi_sequencer_chk import svi_pkg::*; #(
  parameter int unsigned HOLD_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              vec_take_o,
  input logic              insn_done_i,
  input logic              mask_q,
  input logic [FLAG_W-1:0] pend_q,
  input logic [NBANK-1:0]  pend_clr_we,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [PC_W-1:0]   next_pc_i,
  input logic              ccr_c_i,
  input logic              ccr_z_i,
  input logic [PC_W-1:0]   ret_pc_o,
  input logic              ret_c_o,
  input logic              ret_z_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2);

  logic [CW-1:0]     open_cnt;
  logic [FLAG_W-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     open_cnt <= '0;
    else if (mask_q)                open_cnt <= '0;
    else if (open_cnt < CW'(HOLD_CYC)) open_cnt <= open_cnt + 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_clr
    assign clr_mask[b*DATA_W +: DATA_W] = pend_clr_we[b] ? bus_wdata_i : '0;
  end

  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_o);                                                       // R2
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0));                                                // R1
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |-> insn_done_i);                                              // R3
  AST_TAKE_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |=> (mask_q && !irq_o));                                       // R4
  AST_RET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |=> (ret_pc_o == $past(next_pc_i) && ret_c_o == $past(ccr_c_i) && ret_z_o == $past(ccr_z_i))); // R5
  AST_HOLDOFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && open_cnt < CW'(HOLD_CYC)) |-> !irq_o);                        // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~clr_mask) != '0) |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask))); // R8
endmodule

bind svi_sequencer svi_sequencer_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .vec_take_o  (vec_take_o),
  .insn_done_i (insn_done_i),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .pend_clr_we (pend_clr_we),
  .bus_wdata_i (bus_wdata_i),
  .next_pc_i   (next_pc_i),
  .ccr_c_i     (ccr_c_i),
  .ccr_z_i     (ccr_z_i),
  .ret_pc_o    (ret_pc_o),
  .ret_c_o     (ret_c_o),
  .ret_z_o     (ret_z_o)
);

// File: tb/tb_svi_sequencer.sv
module tb_svi_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag_set = '0;
  logic        insn_done = 1'b0;
  logic [13:0] next_pc = '0;
  logic        ccr_c = 1'b0, ccr_z = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq, take, ret_c, ret_z;
  logic [13:0] vec_pc, ret_pc;

  int n_checks = 0;
  int n_errs   = 0;

  // Behavioural reference state
  int m_pend;
  int m_mask;
  int m_hold;
  int m_ret;

  always #(CLK_PERIOD/2) clk = ~clk;

  svi_sequencer dut (
    .clk(clk), .rst_n(rst_n), .flag_set_i(flag_set), .insn_done_i(insn_done),
    .next_pc_i(next_pc), .ccr_c_i(ccr_c), .ccr_z_i(ccr_z),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .vec_take_o(take), .vec_pc_o(vec_pc), .ret_pc_o(ret_pc),
    .ret_c_o(ret_c), .ret_z_o(ret_z)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_irq();
    return (m_pend != 0 && m_mask == 0 && m_hold == 0) ? 1 : 0;
  endfunction

  function automatic int m_read(input int a);
    case (a)
      0: return m_pend & 255;
      1: return (m_pend >> 8) & 255;
      2: return m_mask;
      4: return 188;
      5: return (m_ret >> 8) & 255;
      6: return m_ret & 255;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      0, 1:    return "R8";
      2:       return "R7";
      5, 6:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // One clock: compare outputs, advance the model across the edge.
  task automatic tick();
    int tk, wr;
    #1;
    tk = m_irq() & int'(insn_done);
    chk("R1 irq", int'(irq), m_irq());
    chk("R3 take", int'(take), tk);
    if (tk != 0) chk("R3 vector", int'(vec_pc), 'h3FF7);
    chk("R5 ret_pc", int'(ret_pc), m_ret & 'h3FFF);
    chk("R5 ret_c", int'(ret_c), (m_ret >> 15) & 1);
    chk("R5 ret_z", int'(ret_z), (m_ret >> 14) & 1);
    chk(rd_tag(int'(bus_addr)), int'(bus_rdata), m_read(int'(bus_addr)));
    @(posedge clk);
    wr = int'(bus_sel && bus_we);
    if (wr != 0 && bus_addr == 0) m_pend = m_pend & ~int'(bus_wdata);
    if (wr != 0 && bus_addr == 1) m_pend = m_pend & ~(int'(bus_wdata) << 8);
    m_pend = m_pend | int'(flag_set);
    if (tk != 0) begin
      m_mask = 1; m_hold = 0;
      m_ret = (int'(ccr_c) << 15) | (int'(ccr_z) << 14) | int'(next_pc);
    end else begin
      if (wr != 0 && bus_addr == 2) begin
        if (m_mask == 1 && bus_wdata[0] == 1'b0) m_hold = HOLD;
        else if (bus_wdata[0]) m_hold = 0;
        else if (m_hold > 0) m_hold--;
        m_mask = int'(bus_wdata[0]);
      end else if (m_hold > 0) m_hold--;
      if (wr != 0 && bus_addr == 5) m_ret = (m_ret & 255) | (int'(bus_wdata) << 8);
      if (wr != 0 && bus_addr == 6) m_ret = (m_ret & 'hFF00) | int'(bus_wdata);
    end
    @(negedge clk);
    flag_set = '0; insn_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bwrite(input int a, input int d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    tick();
  endtask

  task automatic bread(input string tag, input int a, input int exp);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'(a);
    #1 chk(tag, int'(bus_rdata), exp);
    tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_pend = 0; m_mask = 1; m_hold = 0; m_ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk("R9 irq", int'(irq), 0);
    bread("R9 mask", 2, 1);
    bread("R9 pend0", 0, 0);
    bread("R9 pend1", 1, 0);
    bread("R9 reth", 5, 0);
    // R2: masked flag is pollable, no request
    flag_set = 16'h0008; tick();
    chk("R2 irq masked", int'(irq), 0);
    bread("R2 poll", 0, 8'h08);
    // R8: write 0 no effect, write 1 clears, set wins collision
    bwrite(0, 8'h00); bread("R8 w0", 0, 8'h08);
    bwrite(0, 8'h08); bread("R8 w1", 0, 8'h00);
    flag_set = 16'h0020; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h20; tick();
    bread("R8 set wins", 0, 8'h20);
    // R7: three-cycle hold-off after unmask
    bwrite(2, 8'h00);
    chk("R7 hold1", int'(irq), 0); tick();
    chk("R7 hold2", int'(irq), 0); tick();
    chk("R7 hold3", int'(irq), 0); tick();
    chk("R7 open", int'(irq), 1);
    // R1: request stays until boundary
    tick(); chk("R1 held", int'(irq), 1);
    // R3 R4 R5: take with C=1 Z=0 PC=0x1234
    next_pc = 14'h1234; ccr_c = 1'b1; ccr_z = 1'b0; insn_done = 1'b1;
    #1 chk("R3 take", int'(take), 1); chk("R3 vec", int'(vec_pc), 'h3FF7);
    tick();
    chk("R4 irq off", int'(irq), 0);
    bread("R4 mask", 2, 1);
    bread("R5 hi", 5, 8'h92);
    bread("R5 lo", 6, 8'h34);
    // R6: exit byte and reserved addresses
    bread("R6 exit", 4, 8'hBC);
    bwrite(4, 8'h00);
    bread("R6 exit kept", 4, 8'hBC);
    bread("R6 rsv3", 3, 0);
    bread("R6 rsv7", 7, 0);
    // R10: unmask with nothing pending
    bwrite(0, 8'hFF);
    bwrite(2, 8'h00);
    repeat (5) begin chk("R10 idle", int'(irq), 0); tick(); end
    flag_set = 16'h2000; tick();
    chk("R10 immediate", int'(irq), 1);
    bread("R10 bank1", 1, 8'h20);
    // R11: software load of return register, then take beats a write
    bwrite(2, 8'h01);
    bwrite(5, 8'h5A); bwrite(6, 8'hC3);
    bread("R11 hi", 5, 8'h5A);
    bread("R11 lo", 6, 8'hC3);
    bwrite(2, 8'h00);
    repeat (HOLD) tick();
    chk("R11 irq", int'(irq), 1);
    next_pc = 14'h3ABC; ccr_c = 1'b0; ccr_z = 1'b1; insn_done = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h11;
    tick();
    bread("R11 cap hi", 5, 8'h7A);
    bread("R11 cap lo", 6, 8'hBC);
    // R2: re-mask mid-pending; no request
    bwrite(2, 8'h01);
    chk("R2 remask", int'(irq), 0);
    repeat (4) tick();
    summary();
  end
endmodule